// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This peripheral keeps time as a 32-bit count of seconds. A prescaler divides the bus clock down to one pulse per second, and each pulse advances the count. The count wraps from all ones to zero. Software can load any starting value into the count. It can also program a 32-bit alarm value. The alarm status bit latches when the count becomes equal to the alarm value.

The alarm status stays set until software writes the clear location. A mask bit gates the status onto a single interrupt line. The block sits in a 4 KB window on a simple 32-bit register bus in the style of APB. There is a setup phase with `psel` high, followed by an access phase with `penable` also high. A write takes effect on the clock edge that ends the access phase. Read data depends only on the address and the current state. A fixed run of eight identification bytes occupies the top of the window.

Top module: `rtc_match_alarm`

## Requirements
- R1: After reset, the count, alarm value, load readback, mask and alarm status all read zero, and `irq` is low.
- R2: The count increases by one every `CLK_PER_SEC` bus clocks, counting from reset release, and wraps modulo 2^32.
- R3: A write to offset 0x08 makes the count read back the written value, and the count then keeps rising from that value. A read of 0x08 returns the last value written there.
- R4: Offset 0x04 holds the alarm value and reads back what was written. The raw status (bit 0 of offset 0x14) is set when a per-second step brings the count equal to the alarm value, including a step that wraps the count to zero.
- R5: A write to 0x04 or 0x08 that leaves the count equal to the alarm value on that same edge sets the raw status at once.
- R6: The raw status holds until it is cleared. If a set and a clear land on the same edge, the set wins.
- R7: Any write to offset 0x1C clears the raw status, whatever the data. A read of 0x1C returns 0.
- R8: Only bit 0 of the mask register at 0x10 exists. `irq`, and bit 0 of the masked status at 0x18, both equal raw status AND mask.
- R9: Offset 0x0C always reads 1, and writes to it are ignored. Writes to 0x00, 0x14 and 0x18 change nothing.
- R10: Reads of offsets 0xFE0, 0xFE4, …, 0xFFC return these bytes in bits 7:0, in order: 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Every other offset, and any address whose two low bits are not zero, reads 0. Writes to such addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the prescaler's source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| irq | output | 1 | Alarm interrupt, raw status AND mask |

## Verification
On every cycle, the checker confirms the following:
- the count holds between pulses and steps by exactly one on a pulse;
- a load lands its value;
- the status is sticky and a clear takes effect;
- an equality step raises the status;
- every edge of `irq` is traced to an edge of status or mask;
- the control location reads 1.

Only bench scenarios can show the rest. This covers the once-per-second rate, the wrap from all ones to zero, an immediate match on a load or alarm write, and the exact collision of a clear with a matching step. It also covers the identification bytes and the silence of the read-only and unmapped locations. Random mixes of loads, alarm writes, clears and reads are compared against a model built from the requirements.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CNT_W = 32;
  localparam int AW    = 12;
  localparam int WIW   = AW - 2;

  localparam logic [WIW-1:0] W_COUNT = 10'h000;
  localparam logic [WIW-1:0] W_ALARM = 10'h001;
  localparam logic [WIW-1:0] W_LOAD  = 10'h002;
  localparam logic [WIW-1:0] W_CTRL  = 10'h003;
  localparam logic [WIW-1:0] W_MASK  = 10'h004;
  localparam logic [WIW-1:0] W_RAW   = 10'h005;
  localparam logic [WIW-1:0] W_MSKD  = 10'h006;
  localparam logic [WIW-1:0] W_CLEAR = 10'h007;

  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h31;
      3'd1: b = 8'h10;
      3'd2: b = 8'h14;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CLK_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CLK_PER_SEC <= 1) begin : g_direct
      assign tick = rst_n;
    end else begin : g_div
      localparam int PW = $clog2(CLK_PER_SEC);
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_SEC - 1);
      logic [PW-1:0] div_q, div_d;
      logic          at_last;

      assign at_last = (div_q == LAST);
      assign tick    = at_last;

      always_comb begin
        if (at_last) div_d = '0;
        else         div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_we,
  input  logic             alarm_we,
  input  logic             clr_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] alarm,
  output logic             raw
);
  logic [CNT_W-1:0] cnt_q, cnt_d, alm_q, alm_d;
  logic             raw_q, raw_d;
  logic             cnt_en, alm_en, raw_en;
  logic             recheck, hit;

  always_comb begin
    cnt_d = cnt_q;
    if (load_we)   cnt_d = wdata;
    else if (tick) cnt_d = cnt_q + 1'b1;
    alm_d   = alarm_we ? wdata : alm_q;
    // Compare the values that will be held after this edge,
    // whenever either side of the comparison moves.
    recheck = load_we | alarm_we | tick;
    hit     = recheck && (cnt_d == alm_d);
    if (hit)         raw_d = 1'b1;
    else if (clr_we) raw_d = 1'b0;
    else             raw_d = raw_q;
  end

  assign cnt_en = load_we | tick;
  assign alm_en = alarm_we;
  assign raw_en = hit | clr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      alm_q <= '0;
      raw_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (alm_en) alm_q <= alm_d;
      if (raw_en) raw_q <= raw_d;
    end
  end

  assign count = cnt_q;
  assign alarm = alm_q;
  assign raw   = raw_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] alarm,
  input  logic             raw,
  output logic [CNT_W-1:0] prdata,
  input  logic [CNT_W-1:0] pwdata,
  output logic             load_we,
  output logic             alarm_we,
  output logic             clr_we,
  output logic             mask
);
  logic             wr_acc, aligned;
  logic [WIW-1:0]   widx;
  logic             mask_we, mask_q, mask_d;
  logic [CNT_W-1:0] ldv_q, ldv_d;
  logic             id_zone;

  assign wr_acc   = psel & penable & pwrite;
  assign aligned  = (paddr[1:0] == 2'b00);
  assign widx     = paddr[AW-1:2];
  assign id_zone  = &widx[WIW-1:3];

  assign load_we  = wr_acc & aligned & (widx == W_LOAD);
  assign alarm_we = wr_acc & aligned & (widx == W_ALARM);
  assign mask_we  = wr_acc & aligned & (widx == W_MASK);
  assign clr_we   = wr_acc & aligned & (widx == W_CLEAR);

  assign ldv_d  = pwdata;
  assign mask_d = pwdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldv_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (load_we) ldv_q  <= ldv_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  always_comb begin
    prdata = '0;
    if (aligned) begin
      if (id_zone) begin
        prdata = {{(CNT_W-8){1'b0}}, ident_byte(widx[2:0])};
      end else begin
        case (widx)
          W_COUNT: prdata = count;
          W_ALARM: prdata = alarm;
          W_LOAD:  prdata = ldv_q;
          W_CTRL:  prdata = {{(CNT_W-1){1'b0}}, 1'b1};
          W_MASK:  prdata = {{(CNT_W-1){1'b0}}, mask_q};
          W_RAW:   prdata = {{(CNT_W-1){1'b0}}, raw};
          W_MSKD:  prdata = {{(CNT_W-1){1'b0}}, raw & mask_q};
          default: prdata = '0;
        endcase
      end
    end
  end

  assign mask = mask_q;
endmodule

// File: rtl/rtc_match_alarm.sv
module rtc_match_alarm
  import rtc_pkg::*;
#(
  parameter int CLK_PER_SEC = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        irq
);
  logic             tick_w;
  logic             load_we, match_we, clr_we;
  logic [CNT_W-1:0] cnt_q, match_q;
  logic             raw_q, mask_q;

  rtc_prescaler #(.CLK_PER_SEC(CLK_PER_SEC)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w)
  );

  rtc_sec_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .load_we (load_we),
    .alarm_we(match_we),
    .clr_we  (clr_we),
    .wdata   (pwdata),
    .count   (cnt_q),
    .alarm   (match_q),
    .raw     (raw_q)
  );

  rtc_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .count   (cnt_q),
    .alarm   (match_q),
    .raw     (raw_q),
    .prdata  (prdata),
    .pwdata  (pwdata),
    .load_we (load_we),
    .alarm_we(match_we),
    .clr_we  (clr_we),
    .mask    (mask_q)
  );

  assign irq = raw_q & mask_q;
endmodule

// File: rtl/rtc_match_alarm_chk.sv
module rtc_match_alarm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic        irq,
  input logic        tick,
  input logic [31:0] cnt_q,
  input logic [31:0] match_q,
  input logic        raw_q,
  input logic        mask_q,
  input logic        load_we,
  input logic        match_we,
  input logic        clr_we
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_we) |=> $stable(cnt_q));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we) |=> (cnt_q == $past(cnt_q) + 32'd1));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr == 12'h008) |=> (cnt_q == $past(pwdata)));

  p_match_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we && !match_we && (cnt_q + 32'd1 == match_q)) |=> raw_q);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr_we) |=> raw_q);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr == 12'h01C && !tick) |=> !raw_q);

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(raw_q) || $rose(mask_q)));

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($fell(raw_q) || $fell(mask_q)));

  p_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == 12'h00C) |-> (prdata == 32'd1));
endmodule

bind rtc_match_alarm rtc_match_alarm_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .prdata  (prdata),
  .irq     (irq),
  .tick    (tick_w),
  .cnt_q   (cnt_q),
  .match_q (match_q),
  .raw_q   (raw_q),
  .mask_q  (mask_q),
  .load_we (load_we),
  .match_we(match_we),
  .clr_we  (clr_we)
);

// File: tb/sim_rtc_match_alarm.sv
`timescale 1ns/1ps
module sim_rtc_match_alarm;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  rtc_match_alarm #(.CLK_PER_SEC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .irq(irq)
  );

  // Reference model built from the requirements.
  int          m_pre;
  logic [31:0] m_cnt, m_mat, m_load, nc, nm;
  logic        m_mask, m_raw, wr, tk, st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = '0; m_mat = '0; m_load = '0;
      m_mask = 1'b0; m_raw = 1'b0;
    end else begin
      wr = psel && penable && pwrite;
      tk = (m_pre == N - 1);
      m_pre = tk ? 0 : m_pre + 1;
      nc = (wr && paddr == 12'h008) ? pwdata : (tk ? m_cnt + 32'd1 : m_cnt);
      nm = (wr && paddr == 12'h004) ? pwdata : m_mat;
      st = (tk || (wr && (paddr == 12'h008 || paddr == 12'h004))) && (nc == nm);
      if (wr && paddr == 12'h008) m_load = pwdata;
      if (wr && paddr == 12'h010) m_mask = pwdata[0];
      if (st) m_raw = 1'b1;
      else if (wr && paddr == 12'h01C) m_raw = 1'b0;
      m_cnt = nc;
      m_mat = nm;
    end
  end

  function automatic logic [7:0] id_exp(input int i);
    case (i)
      0: return 8'h31; 1: return 8'h10; 2: return 8'h14; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a[1:0] != 2'b00) return 32'd0;
    if (a >= 12'hFE0) return {24'd0, id_exp(int'(a[4:2]))};
    case (a)
      12'h000: return m_cnt;
      12'h004: return m_mat;
      12'h008: return m_load;
      12'h00C: return 32'd1;
      12'h010: return {31'd0, m_mask};
      12'h014: return {31'd0, m_raw};
      12'h018: return {31'd0, m_raw & m_mask};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // Reads and compares against the model; returns the sampled data.
  task automatic bus_rd(input logic [11:0] a, input string tag, output logic [31:0] got);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    got = prdata;
    chk(tag, prdata, exp_rd(a));
    chk({tag, " irq R8"}, {31'd0, irq}, {31'd0, m_raw & m_mask});
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_pre(input int p);
    do @(negedge clk); while (m_pre != p);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [11:0] rd_list [10];
    rd_list = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
                12'h014, 12'h018, 12'h01C, 12'hFE8, 12'h020};
    void'($urandom(32'h0005EED5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(12'h000, "R1 count", v);  chk("R1 count zero", v, 32'd0);
    bus_rd(12'h004, "R1 alarm", v);  chk("R1 alarm zero", v, 32'd0);
    bus_rd(12'h008, "R1 load", v);   chk("R1 load zero", v, 32'd0);
    bus_rd(12'h014, "R1 raw", v);    chk("R1 raw zero", v, 32'd0);
    chk("R1 irq low", {31'd0, irq}, 32'd0);

    // R9 control and read-only locations
    bus_wr(12'h00C, 32'h0);
    bus_rd(12'h00C, "R9 ctrl", v);   chk("R9 ctrl reads one", v, 32'd1);
    bus_wr(12'h000, 32'h1234_5678);
    bus_wr(12'h014, 32'hFFFF_FFFF);
    bus_wr(12'h018, 32'hFFFF_FFFF);
    bus_rd(12'h000, "R9 data write ignored", v);
    bus_rd(12'h014, "R9 raw write ignored", v);

    // R10 identification bytes
    for (int i = 0; i < 8; i++) begin
      bus_rd(12'hFE0 + 12'(i * 4), "R10 id", v);
      chk("R10 id literal", v, {24'd0, id_exp(i)});
    end

    // R11 unmapped and misaligned
    bus_rd(12'h020, "R11 unmapped", v);   chk("R11 unmapped zero", v, 32'd0);
    bus_rd(12'h800, "R11 unmapped", v);   chk("R11 unmapped zero", v, 32'd0);
    bus_wr(12'h00A, 32'hDEAD_BEEF);
    bus_rd(12'h008, "R11 misaligned write ignored", v);
    bus_rd(12'h001, "R11 misaligned", v); chk("R11 misaligned zero", v, 32'd0);

    // R3 load, R2 rate
    wait_pre(0);
    bus_wr(12'h008, 32'd100);
    bus_rd(12'h000, "R3 count after load", v); chk("R3 count literal", v, 32'd100);
    bus_rd(12'h008, "R3 load readback", v);    chk("R3 load literal", v, 32'd100);
    wait_pre(0);
    bus_rd(12'h000, "R2 one second later", v); chk("R2 count literal", v, 32'd101);

    // R5 immediate match on alarm write, then R7 clear with zero data
    wait_pre(0);
    bus_wr(12'h004, m_cnt);
    bus_rd(12'h014, "R5 alarm write", v);  chk("R5 raw set", v, 32'd1);
    bus_wr(12'h01C, 32'h0);
    bus_rd(12'h014, "R7 clear", v);        chk("R7 raw cleared", v, 32'd0);
    bus_rd(12'h01C, "R7 clear reads zero", v); chk("R7 read literal", v, 32'd0);

    // R5 immediate match on load write
    wait_pre(0);
    bus_wr(12'h008, m_mat);
    bus_rd(12'h014, "R5 load write", v);   chk("R5 raw set by load", v, 32'd1);

    // R8 masking
    bus_wr(12'h010, 32'hFFFF_FFFE);
    bus_rd(12'h018, "R8 masked off", v);   chk("R8 mis zero", v, 32'd0);
    chk("R8 irq low when masked", {31'd0, irq}, 32'd0);
    bus_wr(12'h010, 32'h0000_0003);
    bus_rd(12'h010, "R8 mask bit0 only", v); chk("R8 mask literal", v, 32'd1);
    bus_rd(12'h018, "R8 masked on", v);    chk("R8 mis one", v, 32'd1);
    chk("R8 irq high", {31'd0, irq}, 32'd1);

    // R4 wrap match
    bus_wr(12'h010, 32'h0);
    bus_wr(12'h01C, 32'h0);
    wait_pre(0);
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_wr(12'h004, 32'h0);
    bus_rd(12'h014, "R4 not yet", v);      chk("R4 raw low before wrap", v, 32'd0);
    wait_pre(0);
    bus_rd(12'h000, "R4 wrapped", v);      chk("R4 count wrapped", v, 32'd0);
    bus_rd(12'h014, "R4 wrap match", v);   chk("R4 raw set at wrap", v, 32'd1);

    // R6 sticky across further seconds
    repeat (2 * N) @(negedge clk);
    bus_rd(12'h014, "R6 sticky", v);       chk("R6 raw still set", v, 32'd1);

    // R6 set beats clear on the same edge
    wait_pre(0);
    bus_wr(12'h01C, 32'h0);
    bus_wr(12'h004, m_cnt + 32'd1);
    wait_pre(N - 3);
    bus_wr(12'h01C, 32'hFFFF_FFFF);
    bus_rd(12'h014, "R6 set wins", v);     chk("R6 raw literal", v, 32'd1);

    // Random mix, all against the model
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0: bus_wr(12'h008, ($urandom % 4 == 0) ? $urandom : m_mat - ($urandom % 3));
        1: bus_wr(12'h004, m_cnt + ($urandom % 3));
        2: bus_wr(12'h010, $urandom);
        3: bus_wr(12'h01C, $urandom);
        4: bus_wr(12'(($urandom % 8) * 4), $urandom);
        default: bus_rd(rd_list[$urandom % 10], "R2 R4 R6 random read", v);
      endcase
      repeat ($urandom % 6) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule